// File: doc/BRIEF.md
# Reset and Strap-Load Sequencer

This block turns two reset sources into a set of timed, overlapping control windows for the rest of a device. The first source is an active-low board reset pin. The second is a reset command that arrives as an in-band message of a chosen type. From either source it produces four controls:

- a core reset, held for a fixed tail after the source clears;
- an output-enable that drops shortly after the source asserts and comes back some time after it clears;
- an active-low PHY reset that stays low for a short extra window once the outputs are enabled again;
- a configuration word taken from strap pins at the end of a pin reset.

A small register port gives two controls. The first is a self-clearing bit that sends a software PHY reset pulse without touching the core. The second is an unlock bit. While it is set, the strap-loaded configuration word can be rewritten in normal operation; while it is clear, that word is read-only.

The pin passes through a two-flop synchronizer. The synchronizer asserts asynchronously and releases on the clock. All windows are counted in system clock cycles from the synchronized pin or from the internal reset.

Top module: `rst_strap_seq`

## Requirements
- R1: While rst_pin_n is low, core_rst is 1, phy_rst_n is 0, cfg_unlock is 0 and phy_sw_pending is 0, and out_en is 0 from the second clock cycle onward.
- R2: After rst_pin_n rises, the first two rising clock edges pass through the synchronizer, and core_rst then stays 1 for 16 further cycles. Counted from the first edge after release, core_rst is 1 for 17 cycles.
- R3: At the end of a pin reset, cfg_value takes the value of strap_pins in the first cycle where core_rst is 0. In the cycle before, it still holds its earlier value.
- R4: A cycle with cmd_valid=1 and cmd_type=4'h3 starts an internal reset of 35 cycles, followed by the 16-cycle core reset tail, so core_rst is 1 for 51 cycles. Any other cmd_type leaves every output unchanged.
- R5: A reset command that arrives while an internal reset is already running reloads the 35-cycle count.
- R6: out_en falls two cycles after the reset source becomes active. It stays 0 until 24 cycles after the source clears.
- R7: phy_rst_n is 0 whenever out_en is 0, and for 8 cycles after out_en returns to 1.
- R8: Writing 1 to bit 1 at wr_addr=0 drives phy_rst_n low for 16 cycles. During those cycles phy_sw_pending reads 1, and it returns to 0 on its own. core_rst and out_en are not affected.
- R9: Bit 0 at wr_addr=0 sets cfg_unlock. A write at wr_addr=1 changes cfg_value only while cfg_unlock is 1.
- R10: A core reset clears cfg_unlock and phy_sw_pending. Register writes are ignored while core_rst is 1. An internal reset leaves cfg_value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Board reset, active low, asynchronous |
| strap_pins | input | CFG_W | Strap levels captured at the end of a pin reset |
| cmd_valid | input | 1 | Strobe for a decoded in-band message |
| cmd_type | input | TYPE_W | Message type; value 3 requests a reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: control bits, 1: configuration word |
| wr_data | input | CFG_W | Write data |
| core_rst | output | 1 | Core reset, active high |
| out_en | output | 1 | Output enable; 0 means device outputs are tri-stated |
| phy_rst_n | output | 1 | PHY reset, active low |
| cfg_value | output | CFG_W | Configuration word |
| cfg_unlock | output | 1 | Configuration word is writable |
| phy_sw_pending | output | 1 | Software PHY reset pulse in progress |

## Verification
The bench measures each window edge to the exact cycle. It does this for a pin reset and for a command reset, because a counter one off in its load value or in its handling of the synchronizer delay would move a single edge by one cycle. It samples the configuration word in the cycle before and the cycle of the core reset release, which catches a strap load that lands early. It sends a second reset command in the middle of a running one, so a design that ignores the retrigger would release the core ten cycles early. It also writes the control bits while a command reset is active: a design that accepts the write would leave the unlock bit set or start a PHY pulse after the reset.

// File: rtl/rss_pkg.sv
package rss_pkg;
    localparam int CNT_W = 8;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t int_cnt;    // internal reset cycles left
        cnt_t core_cnt;   // core reset tail
        cnt_t hiz_cnt;    // tri-state tail
        cnt_t phy_cnt;    // PHY tail after outputs return
        cnt_t sw_cnt;     // software PHY pulse
        cnt_t load_cnt;   // strap load delay
    } seq_t;

    function automatic cnt_t cnt_dec(cnt_t v);
        return (v == '0) ? '0 : v - cnt_t'(1);
    endfunction
endpackage

// File: rtl/rss_sync.sv
module rss_sync (
    input  logic clk,
    input  logic arst_n,
    output logic sync_o
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= 1'b1;
            s2_q <= s1_q;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/rss_cfg.sv
module rss_cfg #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             core_rst,
    input  logic             load_strap,
    input  logic [CFG_W-1:0] strap,
    input  logic             wr_ctrl,
    input  logic             wr_cfg,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_o,
    output logic             unlock_o
);
    logic [CFG_W-1:0] cfg_d, cfg_q;
    logic             unlock_d, unlock_q;

    always_comb begin
        cfg_d    = cfg_q;
        unlock_d = unlock_q;
        if (load_strap)
            cfg_d = strap;
        else if (wr_cfg && unlock_q)
            cfg_d = wr_data;
        if (core_rst)
            unlock_d = 1'b0;
        else if (wr_ctrl)
            unlock_d = wr_data[0];
    end

    always_ff @(posedge clk) begin
        cfg_q    <= cfg_d;
        unlock_q <= unlock_d;
    end

    assign cfg_o    = cfg_q;
    assign unlock_o = unlock_q;
endmodule

// File: rtl/rst_strap_seq.sv
module rst_strap_seq
    import rss_pkg::*;
#(
    parameter int CFG_W       = 8,
    parameter int TYPE_W      = 4,
    parameter int RST_TYPE    = 3,
    parameter int INT_RST_CYC = 35,
    parameter int CORE_TAIL   = 16,
    parameter int TRI_LEAD    = 2,
    parameter int TRI_TAIL    = 24,
    parameter int PHY_TAIL    = 8,
    parameter int SW_PHY_CYC  = 16,
    parameter int STRAP_LOAD  = 16
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic [CFG_W-1:0]  strap_pins,
    input  logic              cmd_valid,
    input  logic [TYPE_W-1:0] cmd_type,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output logic              core_rst,
    output logic              out_en,
    output logic              phy_rst_n,
    output logic [CFG_W-1:0]  cfg_value,
    output logic              cfg_unlock,
    output logic              phy_sw_pending
);
    // tail counter is loaded once the delayed source is seen, so trim the lead
    localparam int HIZ_LOAD = TRI_TAIL - TRI_LEAD;

    logic pin_ok;
    rss_sync u_sync (
        .clk    (clk),
        .arst_n (rst_pin_n),
        .sync_o (pin_ok)
    );

    seq_t                q, d;
    logic [TRI_LEAD-1:0] dly_d, dly_q;
    logic pin_rst, src_act, hiz, core_w, cmd_hit;
    logic wr_ok, wr_ctrl, wr_cfg, load_strap;

    always_comb begin
        pin_rst = !pin_ok;
        src_act = pin_rst || (q.int_cnt != '0);
        hiz     = dly_q[TRI_LEAD-1] || (q.hiz_cnt != '0);
        core_w  = src_act || (q.core_cnt != '0);
        cmd_hit = cmd_valid && (cmd_type == TYPE_W'(RST_TYPE));
        wr_ok   = wr_en && !core_w;
        wr_ctrl = wr_ok && !wr_addr;
        wr_cfg  = wr_ok && wr_addr;
        load_strap = !pin_rst && (q.load_cnt == cnt_t'(1));

        d = q;
        // internal reset: pin reset dominates, a new command restarts the count
        if (pin_rst)
            d.int_cnt = '0;
        else if (cmd_hit)
            d.int_cnt = cnt_t'(INT_RST_CYC);
        else
            d.int_cnt = cnt_dec(q.int_cnt);

        d.core_cnt = src_act ? cnt_t'(CORE_TAIL) : cnt_dec(q.core_cnt);

        dly_d[0] = src_act;
        for (int i = 1; i < TRI_LEAD; i++)
            dly_d[i] = dly_q[i-1];

        d.hiz_cnt  = dly_q[TRI_LEAD-1] ? cnt_t'(HIZ_LOAD) : cnt_dec(q.hiz_cnt);
        d.phy_cnt  = hiz ? cnt_t'(PHY_TAIL) : cnt_dec(q.phy_cnt);

        if (core_w)
            d.sw_cnt = '0;
        else if (wr_ctrl && wr_data[1])
            d.sw_cnt = cnt_t'(SW_PHY_CYC);
        else
            d.sw_cnt = cnt_dec(q.sw_cnt);

        d.load_cnt = pin_rst ? cnt_t'(STRAP_LOAD) : cnt_dec(q.load_cnt);
    end

    always_ff @(posedge clk) begin
        q     <= d;
        dly_q <= dly_d;
    end

    rss_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk        (clk),
        .core_rst   (core_w),
        .load_strap (load_strap),
        .strap      (strap_pins),
        .wr_ctrl    (wr_ctrl),
        .wr_cfg     (wr_cfg),
        .wr_data    (wr_data),
        .cfg_o      (cfg_value),
        .unlock_o   (cfg_unlock)
    );

    assign core_rst       = core_w;
    assign out_en         = !hiz;
    assign phy_sw_pending = (q.sw_cnt != '0);
    assign phy_rst_n      = !(hiz || (q.phy_cnt != '0) || (q.sw_cnt != '0));
endmodule

// File: rtl/rss_checks.sv
module rss_checks #(
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_pin_n,
    input logic             wr_en,
    input logic             core_rst,
    input logic             out_en,
    input logic             phy_rst_n,
    input logic [CFG_W-1:0] cfg_value,
    input logic             cfg_unlock,
    input logic             phy_sw_pending
);
    assert_phy_low_in_hiz_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
        !out_en |-> !phy_rst_n);

    assert_phy_tail_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $rose(out_en) |-> !phy_rst_n);

    assert_sw_pulse_low_R8: assert property (@(posedge clk) disable iff (!rst_pin_n)
        phy_sw_pending |-> !phy_rst_n);

    assert_unlock_by_write_R9: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $rose(cfg_unlock) |-> ($past(wr_en) && !$past(core_rst)));

    assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (!$stable(cfg_value) && !$past(core_rst)) |-> ($past(cfg_unlock) && $past(wr_en)));

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_pin_n)
        core_rst |=> (!cfg_unlock && !phy_sw_pending));
endmodule

bind rst_strap_seq rss_checks #(.CFG_W(CFG_W)) u_chk (
    .clk            (clk),
    .rst_pin_n      (rst_pin_n),
    .wr_en          (wr_en),
    .core_rst       (core_rst),
    .out_en         (out_en),
    .phy_rst_n      (phy_rst_n),
    .cfg_value      (cfg_value),
    .cfg_unlock     (cfg_unlock),
    .phy_sw_pending (phy_sw_pending)
);

// File: tb/tb_rst_strap_seq.sv
module tb_rst_strap_seq;
    localparam int CFG_W = 8;
    localparam int MAXS  = 128;

    logic             clk = 1'b0;
    logic             rst_pin_n = 1'b1;
    logic [CFG_W-1:0] strap_pins = '0;
    logic             cmd_valid = 1'b0;
    logic [3:0]       cmd_type = '0;
    logic             wr_en = 1'b0;
    logic             wr_addr = 1'b0;
    logic [CFG_W-1:0] wr_data = '0;
    logic             core_rst, out_en, phy_rst_n, cfg_unlock, phy_sw_pending;
    logic [CFG_W-1:0] cfg_value;

    int checks = 0;
    int errors = 0;

    logic             core_a [MAXS];
    logic             oe_a   [MAXS];
    logic             phy_a  [MAXS];
    logic             pend_a [MAXS];
    logic [CFG_W-1:0] cfg_a  [MAXS];

    always #10 clk = !clk;

    rst_strap_seq dut (
        .clk(clk), .rst_pin_n(rst_pin_n), .strap_pins(strap_pins),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .core_rst(core_rst), .out_en(out_en), .phy_rst_n(phy_rst_n),
        .cfg_value(cfg_value), .cfg_unlock(cfg_unlock), .phy_sw_pending(phy_sw_pending)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // samples n cycles at negedges; optional second command and one write inside
    task automatic run(input int n, input int cmd_at, input int wr_at,
                       input logic a, input logic [CFG_W-1:0] dat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            core_a[i] = core_rst; oe_a[i] = out_en; phy_a[i] = phy_rst_n;
            pend_a[i] = phy_sw_pending; cfg_a[i] = cfg_value;
            cmd_valid = (i == cmd_at);
            cmd_type  = 4'h3;
            wr_en     = (i == wr_at);
            wr_addr   = a;
            wr_data   = dat;
        end
        cmd_valid = 1'b0;
        wr_en     = 1'b0;
    endtask

    function automatic int ones(input int n, input int which);
        int c = 0;
        for (int i = 0; i < n; i++) begin
            case (which)
                0: c += int'(core_a[i]);
                1: c += int'(!oe_a[i]);
                2: c += int'(!phy_a[i]);
                default: c += int'(pend_a[i]);
            endcase
        end
        return c;
    endfunction

    task automatic do_write(input logic a, input logic [CFG_W-1:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_power_on;
        #1 rst_pin_n = 1'b0;
        strap_pins = 8'hA5;
        repeat (6) @(negedge clk);
        chk("R1 core_rst", int'(core_rst), 1);
        chk("R1 out_en", int'(out_en), 0);
        chk("R1 phy_rst_n", int'(phy_rst_n), 0);
        chk("R1 cfg_unlock", int'(cfg_unlock), 0);
        chk("R1 phy_sw_pending", int'(phy_sw_pending), 0);
        rst_pin_n = 1'b1;
        run(40, -1, -1, 1'b0, '0);
        chk("R2 core_rst cycles", ones(40, 0), 17);
        chk("R2 core_rst release", int'(core_a[16]) * 2 + int'(core_a[17]), 2);
        chk("R3 straps loaded", int'(cfg_a[17]), 'hA5);
        chk("R6 out_en low cycles", ones(40, 1), 25);
        chk("R7 phy low cycles", ones(40, 2), 33);
    endtask

    task automatic t_pin_pulse;
        @(negedge clk);
        strap_pins = 8'h3C;
        rst_pin_n  = 1'b0;
        run(4, -1, -1, 1'b0, '0);
        chk("R1 core_rst on pin", int'(core_a[0]), 1);
        chk("R6 out_en lead first", int'(oe_a[0]), 1);
        chk("R6 out_en lead second", int'(oe_a[1]), 0);
        rst_pin_n = 1'b1;
        run(40, -1, -1, 1'b0, '0);
        chk("R3 old cfg before release", int'(cfg_a[16]), 'hA5);
        chk("R3 new cfg at release", int'(cfg_a[17]), 'h3C);
        chk("R2 core_rst cycles pulse", ones(40, 0), 17);
    endtask

    task automatic t_cmd_reset;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_type = 4'h3;
        run(90, -1, -1, 1'b0, '0);
        chk("R4 core_rst cycles", ones(90, 0), 51);
        chk("R6 out_en held first two", int'(oe_a[0]) + int'(oe_a[1]), 2);
        chk("R6 out_en third low", int'(oe_a[2]), 0);
        chk("R6 out_en low cycles cmd", ones(90, 1), 57);
        chk("R7 phy low cycles cmd", ones(90, 2), 65);
        chk("R7 phy high before hiz", int'(phy_a[1]), 1);
    endtask

    task automatic t_cmd_other;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_type = 4'h5;
        @(negedge clk);
        cmd_valid = 1'b0;
        run(6, -1, -1, 1'b0, '0);
        chk("R4 other type core_rst", ones(6, 0), 0);
        chk("R4 other type out_en", ones(6, 1), 0);
    endtask

    task automatic t_restart;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_type = 4'h3;
        run(100, 9, -1, 1'b0, '0);
        chk("R5 restarted core_rst cycles", ones(100, 0), 61);
    endtask

    task automatic t_sw_phy;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h02;
        run(24, -1, -1, 1'b0, '0);
        chk("R8 phy low cycles", ones(24, 2), 16);
        chk("R8 pending cycles", ones(24, 3), 16);
        chk("R8 pending self-clears", int'(pend_a[15]) * 2 + int'(pend_a[16]), 2);
        chk("R8 core untouched", ones(24, 0), 0);
        chk("R8 out_en untouched", ones(24, 1), 0);
    endtask

    task automatic t_unlock;
        do_write(1'b1, 8'h77);
        chk("R9 locked write ignored", int'(cfg_value), 'h3C);
        do_write(1'b0, 8'h01);
        chk("R9 unlock set", int'(cfg_unlock), 1);
        do_write(1'b1, 8'h77);
        chk("R9 unlocked write", int'(cfg_value), 'h77);
    endtask

    task automatic t_reset_clears;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_type = 4'h3;
        run(90, -1, 5, 1'b0, 8'h03);
        chk("R10 unlock cleared", int'(cfg_unlock), 0);
        chk("R10 pending not started", ones(90, 3), 0);
        chk("R10 cfg kept", int'(cfg_value), 'h77);
    endtask

    initial begin
        t_power_on();
        t_pin_pulse();
        t_cmd_reset();
        t_cmd_other();
        t_restart();
        t_sw_phy();
        t_unlock();
        t_reset_clears();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule